// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the target of subroutine returns in an instruction fetch path. When the front end signals a call, the block records the address of the instruction after the call, which is the call PC plus 4, in a small circular stack. When it signals a return, the block pops the newest recorded address. In the same cycle it presents that address as the predicted next PC and marks the prediction as taken. If more calls arrive than the stack can hold, the top pointer wraps and overwrites the oldest record. The newest call levels therefore stay predictable, and only the deepest ones are lost.

The block also holds a one-bit table, indexed by PC, that learns which fetched instructions are returns. A lookup port reads the bit for any PC in the same cycle. A training port writes the observed outcome back whenever the stored bit disagrees with it. The table comes out of reset as "not a return" everywhere. Decoding of calls and returns, and recovery of the pointer after a misprediction, are handled elsewhere.

Top module: `ras_predictor`

## Requirements
- R1: After reset the occupancy count is 0, no prediction is valid, and the return-detect bit reads 0 for every PC.
- R2: A push stores push PC + 4. A later pop with the stack non-empty drives pred_valid_o high, in the same cycle as the pop, with that value on pred_target_o.
- R3: Pops return the stored addresses newest first, and each push adds 1 to the count while the stack is below its depth.
- R4: pred_taken_o is high exactly when pred_valid_o is high.
- R5: A pop without a push on an empty stack gives pred_valid_o low, and the count stays 0.
- R6: With DEPTH entries occupied, a further push keeps the count at DEPTH and overwrites the oldest entry. After any number of pushes, the following pops return the newest DEPTH values in reverse order of pushing, and then report invalid.
- R7: A push and a pop in the same cycle on a non-empty stack predict the current top, replace it with the new push PC + 4, and leave the count unchanged. On an empty stack the same pair acts as a plain push with no valid prediction.
- R8: The return-detect table is indexed by PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above the index do not affect a lookup, so PCs that differ only there read the same bit.
- R9: A training write sets the indexed bit to the observed value, is visible on lookup from the next cycle, and leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Call seen: record push_pc_i + 4 |
| push_pc_i | input | ADDR_W | PC of the call instruction |
| pop_i | input | 1 | Return seen: pop and predict |
| pred_valid_o | output | 1 | Predicted return target is valid |
| pred_taken_o | output | 1 | Prediction direction (always taken when valid) |
| pred_target_o | output | ADDR_W | Predicted return target |
| count_o | output | CNT_W | Occupied entries, saturating at DEPTH |
| lookup_pc_i | input | ADDR_W | PC to classify as return or not |
| is_ret_o | output | 1 | Return-detect bit for lookup_pc_i |
| train_i | input | 1 | Write the observed return status |
| train_pc_i | input | ADDR_W | PC of the trained instruction |
| train_is_ret_i | input | 1 | Observed status: 1 = return |

## Verification
A push and a pop can fall in the same cycle, as when a return is followed directly by a call. The bench provokes this pair on a stack holding two entries and on an empty stack. In the non-empty case it judges the result by the prediction given in that cycle, by a count that does not change, and by the order of the later pops. In the empty case it expects no valid prediction and a count of one. Overflow is swept over every push count from 1 to DEPTH + 3, and each draining sequence is compared against addresses computed from the push index.

// File: rtl/ras_pkg.sv
// Package ras_pkg: shared types and helpers for the return address stack.
// Assumes instructions are 4 bytes long, so the return address is PC + 4.
package ras_pkg;

    // Stack operation chosen for one cycle
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

    // Map the raw call/return strobes and emptiness to an operation
    function automatic stk_op_e decode_op(input logic push, input logic pop,
                                          input logic empty);
        stk_op_e op;
        if (push && pop && !empty)
            op = STK_SWAP;
        else if (push)
            op = STK_PUSH;
        else if (pop && !empty)
            op = STK_POP;
        else
            op = STK_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/ras_stack.sv
// Module ras_stack: circular storage for return addresses.
// A push writes at the free slot and moves the top pointer up, wrapping
// modulo DEPTH, so overflow overwrites the oldest record. The count
// saturates at DEPTH. A pop moves the pointer down and the count never
// goes below zero. A swap rewrites the current top in place.
// Assumes the operation arrives already decoded (see ras_pkg::decode_op).
module ras_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  stk_op_e                         op_i,
    input  logic [ADDR_W-1:0]               wdata_i,
    output logic [ADDR_W-1:0]               top_o,
    output logic [$clog2(DEPTH+1)-1:0]      count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  free_q;
    logic [PTR_W-1:0]  top_idx;
    logic [PTR_W-1:0]  free_up;
    logic [CNT_W-1:0]  cnt_q;

    // Index of the newest entry: one below the free slot, wrapping
    always_comb begin
        top_idx = (free_q == '0) ? LAST_PTR : free_q - PTR_W'(1);
    end

    // Next free slot after a push, wrapping at the depth
    always_comb begin
        free_up = (free_q == LAST_PTR) ? '0 : free_q + PTR_W'(1);
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '0;
            cnt_q  <= '0;
        end else begin
            case (op_i)
                STK_PUSH: begin
                    free_q <= free_up;
                    if (cnt_q != FULL_CNT)
                        cnt_q <= cnt_q + CNT_W'(1);
                end
                STK_POP: begin
                    free_q <= top_idx;
                    cnt_q  <= cnt_q - CNT_W'(1);
                end
                default: begin
                    free_q <= free_q;
                    cnt_q  <= cnt_q;
                end
            endcase
        end
    end

    // Entry storage, one generated register per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (op_i == STK_PUSH && free_q == PTR_W'(g)) begin
                mem_q[g] <= wdata_i;
            end else if (op_i == STK_SWAP && top_idx == PTR_W'(g)) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    // Present the newest entry and the occupancy
    always_comb begin
        top_o   = mem_q[top_idx];
        count_o = cnt_q;
    end

endmodule

// File: rtl/ras_ret_table.sv
// Module ras_ret_table: one bit per PC-indexed entry that marks returns.
// The index is taken from PC bits [IDX_W+1:2]. The byte offset within a
// word and all higher PC bits are ignored, so aliasing PCs share a bit.
// A training write only changes a bit that disagrees with the outcome.
// Assumes one lookup and one training write per cycle.
module ras_ret_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc_i,
    output logic              rd_bit_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_pc_i,
    input  logic              wr_bit_i
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] bits_q;
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               wrong;

    // Extract the word index of both ports
    always_comb begin
        rd_idx = rd_pc_i[IDX_W+1:2];
        wr_idx = wr_pc_i[IDX_W+1:2];
    end

    // Detect a stored bit that disagrees with the trained outcome
    always_comb begin
        wrong = wr_en_i && (bits_q[wr_idx] != wr_bit_i);
    end

    // Correct the table entry when the prediction was wrong
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wrong) begin
            bits_q[wr_idx] <= wr_bit_i;
        end
    end

    // Read the stored prediction for the lookup PC
    always_comb begin
        rd_bit_o = bits_q[rd_idx];
    end

endmodule

// File: rtl/ras_predictor.sv
// Module ras_predictor: top of the return address predictor.
// Combines the circular stack (call/return targets) with the learned
// return-detect table. A pop prediction is combinational from the current
// top of stack and is always marked taken when valid.
// Assumes push_i/pop_i come from a decoder outside this block.
module ras_predictor
    import ras_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [ADDR_W-1:0]          push_pc_i,
    input  logic                       pop_i,
    output logic                       pred_valid_o,
    output logic                       pred_taken_o,
    output logic [ADDR_W-1:0]          pred_target_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    input  logic [ADDR_W-1:0]          lookup_pc_i,
    output logic                       is_ret_o,
    input  logic                       train_i,
    input  logic [ADDR_W-1:0]          train_pc_i,
    input  logic                       train_is_ret_i
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    stk_op_e           op;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] top;
    logic [CNT_W-1:0]  cnt;
    logic              empty;

    // Return address of the call being pushed
    always_comb begin
        ret_addr = push_pc_i + INSN_BYTES;
    end

    // Choose this cycle's stack operation
    always_comb begin
        empty = (cnt == '0);
        op    = decode_op(push_i, pop_i, empty);
    end

    ras_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) stack_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .wdata_i (ret_addr),
        .top_o   (top),
        .count_o (cnt)
    );

    ras_ret_table #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc_i  (lookup_pc_i),
        .rd_bit_o (is_ret_o),
        .wr_en_i  (train_i),
        .wr_pc_i  (train_pc_i),
        .wr_bit_i (train_is_ret_i)
    );

    // Drive the prediction from the top of stack on a non-empty pop
    always_comb begin
        pred_valid_o  = pop_i && !empty;
        pred_taken_o  = pred_valid_o;
        pred_target_o = pred_valid_o ? top : '0;
        count_o       = cnt;
    end

endmodule

// File: rtl/ras_predictor_chk.sv
// Module ras_predictor_chk: temporal checks on the predictor ports.
// Attached to every ras_predictor instance by the bind below.
module ras_predictor_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push_i,
    input logic                       pop_i,
    input logic                       pred_valid_o,
    input logic                       pred_taken_o,
    input logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // R4
    taken_tracks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o == pred_valid_o);

    // R5
    empty_pop_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o == '0) |-> !pred_valid_o);

    // R5
    empty_pop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o == '0) |=> count_o == '0);

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL_CNT);

    // R6
    full_push_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count_o == FULL_CNT) |=> count_o == FULL_CNT);

    // R3
    push_counts_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count_o != FULL_CNT) |=> count_o == $past(count_o) + CNT_W'(1));

    // R7
    swap_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && count_o != '0) |=> $stable(count_o));

    // R2
    pop_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1));

endmodule

bind ras_predictor ras_predictor_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .pred_valid_o (pred_valid_o),
    .pred_taken_o (pred_taken_o),
    .count_o      (count_o)
);

// File: tb/ras_predictor_tb_top.sv
`timescale 1ns/1ps
module ras_predictor_tb_top;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              push_i;
    logic [ADDR_W-1:0] push_pc_i;
    logic              pop_i;
    logic              pred_valid_o;
    logic              pred_taken_o;
    logic [ADDR_W-1:0] pred_target_o;
    logic [CNT_W-1:0]  count_o;
    logic [ADDR_W-1:0] lookup_pc_i;
    logic              is_ret_o;
    logic              train_i;
    logic [ADDR_W-1:0] train_pc_i;
    logic              train_is_ret_i;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ras_predictor #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_pc_i(push_pc_i),
        .pop_i(pop_i), .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
        .pred_target_o(pred_target_o), .count_o(count_o),
        .lookup_pc_i(lookup_pc_i), .is_ret_o(is_ret_o), .train_i(train_i),
        .train_pc_i(train_pc_i), .train_is_ret_i(train_is_ret_i)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        push_i = 0; pop_i = 0; train_i = 0;
        push_pc_i = '0; train_pc_i = '0; train_is_ret_i = 0;
    endtask

    // Let the edge commit, return at the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic push(input logic [ADDR_W-1:0] pc);
        idle(); push_i = 1; push_pc_i = pc;
        tick(); idle();
    endtask

    // Pop and compare the same-cycle prediction
    task automatic pop_expect(input bit exp_v, input logic [ADDR_W-1:0] exp_t, input string req);
        idle(); pop_i = 1;
        #0.5;
        chk(pred_valid_o == exp_v, req, pred_valid_o, exp_v);
        chk(pred_taken_o == exp_v, "R4", pred_taken_o, exp_v);
        if (exp_v) chk(pred_target_o == exp_t, req, pred_target_o, exp_t);
        tick(); idle();
    endtask

    function automatic logic [ADDR_W-1:0] call_pc(input int n, input int i);
        return ADDR_W'(32'h0004_0000 + n * 32'h1000 + i * 8);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        lookup_pc_i = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(count_o == 0, "R1", count_o, 0);
        pop_i = 1; #0.5;
        chk(pred_valid_o == 0, "R1", pred_valid_o, 0);
        pop_i = 0;
        for (int i = 0; i < (1 << IDX_W); i++) begin
            lookup_pc_i = ADDR_W'(i << 2) | ADDR_W'(i & 3);
            #0.1;
            chk(is_ret_o == 0, "R1", is_ret_o, 0);
        end

        // R5 pop on empty does nothing
        pop_expect(0, '0, "R5");
        chk(count_o == 0, "R5", count_o, 0);

        // R2 R3 R6 sweep over push counts
        for (int n = 1; n <= DEPTH + 3; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) begin
                int e;
                push(call_pc(n, i));
                e = (i + 1 < DEPTH) ? i + 1 : DEPTH;
                chk(count_o == CNT_W'(e), (i + 1 > DEPTH) ? "R6" : "R3", count_o, e);
            end
            for (int j = 0; j <= DEPTH; j++) begin
                int kept;
                kept = (n < DEPTH) ? n : DEPTH;
                if (j < kept)
                    pop_expect(1, call_pc(n, n - 1 - j) + 4, (n > DEPTH) ? "R6" : "R2");
                else
                    pop_expect(0, '0, (n > DEPTH) ? "R6" : "R5");
            end
            chk(count_o == 0, "R3", count_o, 0);
        end

        // R7 simultaneous push and pop on a non-empty stack
        do_reset();
        push(32'h100); push(32'h200);
        idle(); push_i = 1; pop_i = 1; push_pc_i = 32'h300;
        #0.5;
        chk(pred_valid_o == 1, "R7", pred_valid_o, 1);
        chk(pred_target_o == 32'h204, "R7", pred_target_o, 32'h204);
        tick(); idle();
        chk(count_o == 2, "R7", count_o, 2);
        pop_expect(1, 32'h304, "R7");
        pop_expect(1, 32'h104, "R7");
        pop_expect(0, '0, "R7");

        // R7 on an empty stack the pair is a plain push
        do_reset();
        idle(); push_i = 1; pop_i = 1; push_pc_i = 32'h500;
        #0.5;
        chk(pred_valid_o == 0, "R7", pred_valid_o, 0);
        tick(); idle();
        chk(count_o == 1, "R7", count_o, 1);
        pop_expect(1, 32'h504, "R7");

        // R9 train every index, pattern: index divisible by 3 is a return
        for (int i = 0; i < (1 << IDX_W); i++) begin
            idle(); train_i = 1;
            train_pc_i = ADDR_W'(i << 2);
            train_is_ret_i = (i % 3 == 0);
            tick();
        end
        idle();
        // R8 lookups with offset bits and high bits changed (aliases)
        for (int i = 0; i < (1 << IDX_W); i++) begin
            lookup_pc_i = ADDR_W'(32'hABC0_0000 | (i << 2) | 3);
            #0.1;
            chk(is_ret_o == (i % 3 == 0), "R8", is_ret_o, (i % 3 == 0));
        end

        // R9 clearing one entry changes only that entry
        idle(); train_i = 1; train_pc_i = ADDR_W'(9 << 2); train_is_ret_i = 0;
        lookup_pc_i = ADDR_W'(9 << 2); #0.5;
        chk(is_ret_o == 1, "R9", is_ret_o, 1);
        tick(); idle();
        chk(is_ret_o == 0, "R9", is_ret_o, 0);
        for (int i = 0; i < (1 << IDX_W); i++) begin
            lookup_pc_i = ADDR_W'(i << 2);
            #0.1;
            if (i != 9) chk(is_ret_o == (i % 3 == 0), "R9", is_ret_o, (i % 3 == 0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule